// File: doc/BRIEF.md
# Pen-Positioned Tile Blitter

This block draws 8x8-bit tiles from an on-chip tile cache into a frame buffer that is itself stored as a grid of tiles. It behaves like character output on a terminal. A pen position, in tile units, says where the next drawing lands. After every drawing command the pen moves right by the width of what was drawn. A clip window confines writes to a rectangle that starts at the pen. Any tile that would fall outside that window, or outside the frame buffer, is skipped as a whole.

Two drawing commands exist. The sprite command XORs a rectangular block of cached tiles into the frame buffer, so drawing it a second time erases it. The fill command stamps one cached tile repeatedly across a rectangle and overwrites what was there. The block reads the tile cache through a read port with one cycle of latency. It reaches the frame buffer through a read-modify-write port that also has one cycle of read latency.

The state machine has four states. IDLE accepts commands. TILE tests the clip for the current tile: a visible tile moves to READ, a skipped tile moves to the next tile or back to IDLE. READ issues the cache read and, for XOR, the frame-buffer read, and always moves to WRITE. WRITE stores one byte, then returns to READ for the next line, moves to TILE for the next tile, or goes to IDLE after the last tile.

Top module: `pen_tile_blitter`

## Requirements
- R1: After reset, busy is 0, the pen is at (0,0), the clip window covers the whole frame buffer, and no frame-buffer write occurs.
- R2: A set-pen command (cmd_op 0) loads pen_x from cmd_arg[7:0] and pen_y from cmd_arg[15:8] at the accepting edge, without raising busy.
- R3: A set-clip command (cmd_op 1) makes the window run from the current pen over cmd_arg[7:0] columns and cmd_arg[15:8] rows. Columns pen_x to pen_x+dx-1 and rows pen_y to pen_y+dy-1 are inside; no tile outside is written.
- R4: A sprite command (cmd_op 2, cmd_arg = height*256+width) draws the tile at row r, column c of the block from cache tile cmd_tile + r*width + c. Line k of that tile is written as cache byte XOR frame byte at address ty*FB_COLS*8 + tx*8 + k, where tx = pen_x+c and ty = pen_y+r.
- R5: A fill command (cmd_op 3, cmd_arg = yrep*256+xrep) writes cache tile cmd_tile unchanged at every position of the xrep by yrep rectangle. It never reads the frame buffer.
- R6: After a sprite or fill command, pen_x has advanced by the width (or xrep) modulo 256. pen_y is unchanged. This holds even when every tile was clipped.
- R7: Clipping works per tile: a tile is written completely or not at all. Tiles with tx >= FB_COLS or ty >= FB_ROWS are never written. A skipped tile costs one busy cycle.
- R8: busy is high from the cycle after a sprite or fill command is accepted until the command finishes. Any command presented while busy is ignored.
- R9: A sprite or fill command with a width or height of zero writes nothing and never raises busy. The pen still advances by the width.
- R10: Each visible line takes two cycles: a read cycle, then a write cycle that uses data returned one cycle after the read. A single visible tile keeps busy high for 17 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present; accepted only while idle |
| cmd_op | input | 2 | 0 set pen, 1 set clip, 2 XOR sprite, 3 fill |
| cmd_arg | input | 16 | High byte: y / height / yrep; low byte: x / width / xrep |
| cmd_tile | input | TILE_W (6) | First cache tile index |
| busy | output | 1 | A drawing command is in progress |
| pen_x | output | 8 | Pen column in tiles |
| pen_y | output | 8 | Pen row in tiles |
| tc_rd_en | output | 1 | Tile cache read strobe |
| tc_addr | output | TC_AW (9) | Tile cache byte address, tile*8+line |
| tc_rdata | input | 8 | Tile cache data, one cycle after the strobe |
| fb_rd_en | output | 1 | Frame-buffer read strobe |
| fb_wr_en | output | 1 | Frame-buffer write strobe |
| fb_addr | output | FB_AW (12) | Frame-buffer byte address |
| fb_rdata | input | 8 | Frame-buffer data, one cycle after the strobe |
| fb_wdata | output | 8 | Frame-buffer write data |

## Verification
A wrong pen or clip register shows up at the next drawing command. Bytes then land at shifted tile addresses, or tiles go missing, and a comparison of the whole frame buffer with an independent model catches this as soon as that command ends. The pen ports expose a bad advance right after the command. A tile counter or a line counter that is off by one changes either the busy length, which is counted cycle by cycle, or the last line of a tile. A mode bit latched with the wrong value turns a fill into an XOR or the reverse, so every byte under the rectangle differs, and it also lets frame-buffer reads appear during a fill.

// File: rtl/ptb_pkg.sv
`timescale 1ns/1ps
package ptb_pkg;
    typedef enum logic [1:0] {
        OP_PEN  = 2'd0,
        OP_CLIP = 2'd1,
        OP_XOR  = 2'd2,
        OP_FILL = 2'd3
    } ptb_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TILE  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } ptb_state_e;
endpackage

// File: rtl/ptb_clip.sv
`timescale 1ns/1ps
module ptb_clip #(
    parameter int FB_COLS = 20,
    parameter int FB_ROWS = 20
) (
    input  logic [8:0] tx,
    input  logic [8:0] ty,
    input  logic [7:0] win_x0,
    input  logic [7:0] win_y0,
    input  logic [8:0] win_x1,
    input  logic [8:0] win_y1,
    output logic       visible
);
    logic in_win;
    logic on_screen;

    always_comb begin
        in_win    = ({1'b0, win_x0} <= tx) && (tx < win_x1) &&
                    ({1'b0, win_y0} <= ty) && (ty < win_y1);
        on_screen = (tx < 9'(FB_COLS)) && (ty < 9'(FB_ROWS));
        visible   = in_win && on_screen;
    end
endmodule

// File: rtl/ptb_addr.sv
`timescale 1ns/1ps
module ptb_addr #(
    parameter int FB_COLS     = 20,
    parameter int FB_ROWS     = 20,
    parameter int TILE_LINES  = 8,
    parameter int CACHE_TILES = 51,
    localparam int FB_BYTES   = FB_COLS * FB_ROWS * TILE_LINES,
    localparam int FB_AW      = $clog2(FB_BYTES),
    localparam int TILE_W     = $clog2(CACHE_TILES),
    localparam int TC_AW      = $clog2(CACHE_TILES * TILE_LINES),
    localparam int LINE_W     = $clog2(TILE_LINES),
    localparam int ROW_BYTES  = FB_COLS * TILE_LINES
) (
    input  logic [8:0]        tx,
    input  logic [8:0]        ty,
    input  logic [LINE_W-1:0] line,
    input  logic [TILE_W-1:0] tile,
    output logic [FB_AW-1:0]  fb_addr,
    output logic [TC_AW-1:0]  tc_addr
);
    always_comb begin
        fb_addr = FB_AW'(ty) * FB_AW'(ROW_BYTES)
                + FB_AW'(tx) * FB_AW'(TILE_LINES)
                + FB_AW'(line);
        tc_addr = TC_AW'(tile) * TC_AW'(TILE_LINES) + TC_AW'(line);
    end
endmodule

// File: rtl/pen_tile_blitter.sv
`timescale 1ns/1ps
module pen_tile_blitter
    import ptb_pkg::*;
#(
    parameter int FB_COLS     = 20,
    parameter int FB_ROWS     = 20,
    parameter int TILE_LINES  = 8,
    parameter int CACHE_TILES = 51,
    localparam int FB_BYTES   = FB_COLS * FB_ROWS * TILE_LINES,
    localparam int FB_AW      = $clog2(FB_BYTES),
    localparam int TILE_W     = $clog2(CACHE_TILES),
    localparam int TC_AW      = $clog2(CACHE_TILES * TILE_LINES),
    localparam int LINE_W     = $clog2(TILE_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [15:0]       cmd_arg,
    input  logic [TILE_W-1:0] cmd_tile,
    output logic              busy,
    output logic [7:0]        pen_x,
    output logic [7:0]        pen_y,
    output logic              tc_rd_en,
    output logic [TC_AW-1:0]  tc_addr,
    input  logic [7:0]        tc_rdata,
    output logic              fb_rd_en,
    output logic              fb_wr_en,
    output logic [FB_AW-1:0]  fb_addr,
    input  logic [7:0]        fb_rdata,
    output logic [7:0]        fb_wdata
);
    ptb_state_e        state, state_d;
    ptb_op_e           op;
    logic              mode_xor;
    logic [7:0]        blk_w, blk_h, col, row;
    logic [LINE_W-1:0] line;
    logic [TILE_W-1:0] cur_tile;
    logic [7:0]        win_x0, win_y0;
    logic [8:0]        win_x1, win_y1;
    logic [8:0]        tile_x, tile_y;
    logic              visible, last_col, last_row, last_line;
    logic              step, done, start, empty;

    assign op = ptb_op_e'(cmd_op);

    ptb_clip #(.FB_COLS(FB_COLS), .FB_ROWS(FB_ROWS)) u_clip (
        .tx(tile_x), .ty(tile_y),
        .win_x0(win_x0), .win_y0(win_y0), .win_x1(win_x1), .win_y1(win_y1),
        .visible(visible)
    );

    ptb_addr #(.FB_COLS(FB_COLS), .FB_ROWS(FB_ROWS), .TILE_LINES(TILE_LINES),
               .CACHE_TILES(CACHE_TILES)) u_addr (
        .tx(tile_x), .ty(tile_y), .line(line), .tile(cur_tile),
        .fb_addr(fb_addr), .tc_addr(tc_addr)
    );

    // Position and termination of the walk over the block.
    always_comb begin
        tile_x    = {1'b0, pen_x} + {1'b0, col};
        tile_y    = {1'b0, pen_y} + {1'b0, row};
        last_col  = (col == blk_w - 8'd1);
        last_row  = (row == blk_h - 8'd1);
        last_line = (line == LINE_W'(TILE_LINES - 1));
        step      = ((state == ST_TILE) && !visible) ||
                    ((state == ST_WRITE) && last_line);
        done      = step && last_col && last_row;
        start     = (state == ST_IDLE) && cmd_valid &&
                    ((op == OP_XOR) || (op == OP_FILL));
        empty     = (cmd_arg[7:0] == 8'd0) || (cmd_arg[15:8] == 8'd0);
    end

    // Next-state logic.
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  state_d = (start && !empty) ? ST_TILE : ST_IDLE;
            ST_TILE:  state_d = visible ? ST_READ : (done ? ST_IDLE : ST_TILE);
            ST_READ:  state_d = ST_WRITE;
            ST_WRITE: state_d = !last_line ? ST_READ : (done ? ST_IDLE : ST_TILE);
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // Pen, clip window and walk counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pen_x    <= '0;
            pen_y    <= '0;
            win_x0   <= '0;
            win_y0   <= '0;
            win_x1   <= 9'(FB_COLS);
            win_y1   <= 9'(FB_ROWS);
            mode_xor <= 1'b0;
            blk_w    <= '0;
            blk_h    <= '0;
            col      <= '0;
            row      <= '0;
            line     <= '0;
            cur_tile <= '0;
        end else if (state == ST_IDLE) begin
            if (cmd_valid) begin
                unique case (op)
                    OP_PEN: begin
                        pen_x <= cmd_arg[7:0];
                        pen_y <= cmd_arg[15:8];
                    end
                    OP_CLIP: begin
                        win_x0 <= pen_x;
                        win_y0 <= pen_y;
                        win_x1 <= {1'b0, pen_x} + {1'b0, cmd_arg[7:0]};
                        win_y1 <= {1'b0, pen_y} + {1'b0, cmd_arg[15:8]};
                    end
                    OP_XOR, OP_FILL: begin
                        mode_xor <= (op == OP_XOR);
                        blk_w    <= cmd_arg[7:0];
                        blk_h    <= cmd_arg[15:8];
                        col      <= '0;
                        row      <= '0;
                        line     <= '0;
                        cur_tile <= cmd_tile;
                        if (empty) pen_x <= pen_x + cmd_arg[7:0];
                    end
                endcase
            end
        end else if (step) begin
            line <= '0;
            if (mode_xor) cur_tile <= cur_tile + 1'b1;
            if (last_col) begin
                col <= '0;
                row <= row + 8'd1;
            end else begin
                col <= col + 8'd1;
            end
            if (done) pen_x <= pen_x + blk_w;
        end else if (state == ST_WRITE) begin
            line <= line + 1'b1;
        end
    end

    // Port outputs.
    always_comb begin
        busy     = (state != ST_IDLE);
        tc_rd_en = (state == ST_READ);
        fb_rd_en = (state == ST_READ) && mode_xor;
        fb_wr_en = (state == ST_WRITE);
        fb_wdata = mode_xor ? (tc_rdata ^ fb_rdata) : tc_rdata;
    end

    // R8
    pen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || ($stable(pen_x) && $stable(pen_y))));

    // R5
    fill_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mode_xor) |-> !fb_rd_en);

    // R7
    wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_wr_en |-> (32'(fb_addr) < FB_BYTES));

    // R10
    rmw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_rd_en |=> (fb_wr_en && $stable(fb_addr)));

    // R8
    wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fb_wr_en |-> busy);
endmodule

// File: tb/pen_tile_blitter_tb.sv
`timescale 1ns/1ps
module pen_tile_blitter_tb;
    localparam int COLS = 20, ROWS = 20, LINES = 8;
    localparam int FB_BYTES = COLS * ROWS * LINES;

    // {op[2], arg[16], tile[6], exp_pen_x[8], exp_pen_y[8]}
    localparam logic [39:0] VEC [16] = '{
        {2'd0, 16'h0302, 6'd0, 8'd2,   8'd3},
        {2'd2, 16'h0202, 6'd1, 8'd4,   8'd3},
        {2'd0, 16'h0513, 6'd0, 8'd19,  8'd5},
        {2'd2, 16'h0102, 6'd5, 8'd21,  8'd5},
        {2'd0, 16'h0A04, 6'd0, 8'd4,   8'd10},
        {2'd1, 16'h0203, 6'd0, 8'd4,   8'd10},
        {2'd0, 16'h0A03, 6'd0, 8'd3,   8'd10},
        {2'd3, 16'h0303, 6'd7, 8'd6,   8'd10},
        {2'd0, 16'h0B05, 6'd0, 8'd5,   8'd11},
        {2'd2, 16'h0103, 6'd9, 8'd8,   8'd11},
        {2'd2, 16'h0002, 6'd3, 8'd10,  8'd11},
        {2'd0, 16'h0000, 6'd0, 8'd0,   8'd0},
        {2'd1, 16'h1414, 6'd0, 8'd0,   8'd0},
        {2'd3, 16'h0102, 6'd2, 8'd2,   8'd0},
        {2'd0, 16'h00FA, 6'd0, 8'd250, 8'd0},
        {2'd2, 16'h0108, 6'd0, 8'd2,   8'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [15:0] cmd_arg = '0;
    logic [5:0]  cmd_tile = '0;
    logic        busy, tc_rd_en, fb_rd_en, fb_wr_en;
    logic [7:0]  pen_x, pen_y, fb_wdata;
    logic [7:0]  tc_rdata = '0;
    logic [7:0]  fb_rdata = '0;
    logic [8:0]  tc_addr;
    logic [11:0] fb_addr;

    logic [7:0] fb_mem   [FB_BYTES];
    logic [7:0] model_fb [FB_BYTES];
    int m_px, m_py, m_cx0, m_cy0, m_cx1, m_cy1;
    int n_chk = 0, n_fail = 0, wr_cnt = 0, rd_cnt = 0, busy_cycles = 0;

    always #4 clk = ~clk;

    pen_tile_blitter u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .cmd_tile(cmd_tile), .busy(busy),
        .pen_x(pen_x), .pen_y(pen_y), .tc_rd_en(tc_rd_en), .tc_addr(tc_addr),
        .tc_rdata(tc_rdata), .fb_rd_en(fb_rd_en), .fb_wr_en(fb_wr_en),
        .fb_addr(fb_addr), .fb_rdata(fb_rdata), .fb_wdata(fb_wdata)
    );

    function automatic logic [7:0] tc_pat(int a);
        return 8'((a * 37 + 5) ^ (a >> 3));
    endfunction

    function automatic logic [7:0] fb_init(int a);
        return 8'(a * 11 + 3);
    endfunction

    // Memories behind the two ports, one cycle of read latency each.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < FB_BYTES; i++) fb_mem[i] <= fb_init(i);
        end else begin
            if (fb_wr_en) begin
                fb_mem[fb_addr] <= fb_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (fb_rd_en) begin
                fb_rdata <= fb_mem[fb_addr];
                rd_cnt <= rd_cnt + 1;
            end
        end
        if (tc_rd_en) tc_rdata <= tc_pat(int'(tc_addr));
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_fb(string req);
        int bad = 0;
        for (int i = 0; i < FB_BYTES; i++)
            if (fb_mem[i] !== model_fb[i]) bad++;
        chk(bad == 0, req, "frame buffer bytes differing from model", bad, 0);
    endtask

    // Reference behaviour taken from R2..R7 and R9.
    task automatic model_apply(int op, int arg, int tile);
        int w, h, tx, ty, a, t;
        w = arg & 255;
        h = arg >> 8;
        case (op)
            0: begin m_px = w; m_py = h; end
            1: begin m_cx0 = m_px; m_cy0 = m_py; m_cx1 = m_px + w; m_cy1 = m_py + h; end
            default: begin
                for (int r = 0; r < h; r++)
                    for (int c = 0; c < w; c++) begin
                        tx = m_px + c;
                        ty = m_py + r;
                        if (tx >= m_cx0 && tx < m_cx1 && ty >= m_cy0 && ty < m_cy1 &&
                            tx < COLS && ty < ROWS)
                            for (int k = 0; k < LINES; k++) begin
                                a = ty * COLS * LINES + tx * LINES + k;
                                t = (op == 2) ? (tile + r * w + c) : tile;
                                if (op == 2) model_fb[a] = model_fb[a] ^ tc_pat(t * LINES + k);
                                else         model_fb[a] = tc_pat(t * LINES + k);
                            end
                    end
                m_px = (m_px + w) % 256;
            end
        endcase
    endtask

    task automatic send(int op, int arg, int tile);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 2'(op);
        cmd_arg   = 16'(arg);
        cmd_tile  = 6'(tile);
        @(negedge clk);
        cmd_valid = 1'b0;
        busy_cycles = 0;
        while (busy) begin
            busy_cycles++;
            @(negedge clk);
        end
        model_apply(op, arg, tile);
    endtask

    function automatic string op_req(int op);
        case (op)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R8 watchdog expired: actual busy %0d expected 0", busy);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int rd_before;
        for (int i = 0; i < FB_BYTES; i++) model_fb[i] = fb_init(i);
        m_px = 0; m_py = 0; m_cx0 = 0; m_cy0 = 0; m_cx1 = COLS; m_cy1 = ROWS;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(pen_x == 8'd0 && pen_y == 8'd0, "R1", "pen after reset",
            int'(pen_x) * 256 + int'(pen_y), 0);
        chk(wr_cnt == 0, "R1", "writes after reset", wr_cnt, 0);
        check_fb("R1");

        // Table walk: R2 R3 R4 R5 R6 R7 R9
        foreach (VEC[i]) begin
            int op, arg, tile;
            op   = int'(VEC[i][39:38]);
            arg  = int'(VEC[i][37:22]);
            tile = int'(VEC[i][21:16]);
            rd_before = rd_cnt;
            send(op, arg, tile);
            chk(pen_x == VEC[i][15:8], (op >= 2) ? "R6" : op_req(op), "pen_x",
                pen_x, int'(VEC[i][15:8]));
            chk(pen_y == VEC[i][7:0], (op >= 2) ? "R6" : op_req(op), "pen_y",
                pen_y, int'(VEC[i][7:0]));
            if (op >= 2) check_fb(op_req(op));
            if (op == 3) chk(rd_cnt == rd_before, "R5", "frame reads during fill",
                             rd_cnt - rd_before, 0);
            if (op >= 2 && ((arg & 255) == 0 || (arg >> 8) == 0))
                chk(busy_cycles == 0, "R9", "busy cycles for empty block", busy_cycles, 0);
        end

        // R8 and R10: commands during busy are ignored; one tile takes 17 cycles
        send(0, 16'h0101, 0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_arg = 16'h0101; cmd_tile = 6'd4;
        @(negedge clk);
        busy_cycles = 0;
        for (int j = 0; j < 3; j++) begin
            if (busy) busy_cycles++;
            cmd_valid = 1'b1; cmd_op = (j == 1) ? 2'd3 : 2'd0;
            cmd_arg = 16'h0909; cmd_tile = 6'd20;
            @(negedge clk);
        end
        cmd_valid = 1'b0;
        while (busy) begin
            busy_cycles++;
            @(negedge clk);
        end
        model_apply(2, 16'h0101, 4);
        chk(busy_cycles == 17, "R10", "busy cycles for one visible tile", busy_cycles, 17);
        chk(pen_x == 8'd2 && pen_y == 8'd1, "R8", "pen after ignored commands",
            int'(pen_x) * 256 + int'(pen_y), 2 * 256 + 1);
        check_fb("R8");

        // R7: a tile off the right edge is skipped in one cycle
        send(0, 16'h001E, 0);
        send(2, 16'h0101, 0);
        chk(busy_cycles == 1, "R7", "busy cycles for skipped tile", busy_cycles, 1);
        chk(pen_x == 8'd31, "R6", "pen_x after skipped tile", pen_x, 31);
        check_fb("R7");

        // R9: zero height fill
        send(3, 16'h0005, 1);
        chk(busy_cycles == 0, "R9", "busy cycles for zero height", busy_cycles, 0);
        chk(pen_x == 8'd36, "R9", "pen_x after zero height", pen_x, 36);
        check_fb("R9");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule